// File: doc/BRIEF.md
# Multiport Packet Sender with In-Band Port Select

This block sits on the PHY side of a byte-wide receive path toward a link-layer device. Several per-port byte queues are filled from a shared write port, and the block moves their contents onto one data bus. Each burst opens with a single address cycle, in which a select strobe is high and the bus carries the index of the port whose bytes follow. The bytes then go out under a valid strobe, with start and end markers that frame each packet.

The link device paces the whole exchange with one read-enable input. The block only starts an address cycle or sends a byte when that enable was high at the clock edge before. When the enable drops in the middle of a burst, valid goes low and the bus holds its value, and the burst resumes with no byte lost or repeated. A port may send once it holds a whole packet or at least a set number of bytes. Ports that may send are served in rotating order. If a queue runs dry in the middle of a packet, the burst closes without an end marker, and the packet's next burst carries no start marker.

Top module: `mport_rx_sender`

## Requirements
- R1: After reset, bus_sel, bus_val, bus_sop and bus_eop are low, bus_data is zero and in_full is zero.
- R2: bus_sel is high for exactly one cycle at a time, only when link_ren was high at the previous rising edge. During that cycle bus_data carries the port index, zero-extended.
- R3: The bytes sent after a select cycle come from the announced port, in write order, with none lost or repeated. bus_sop is high exactly on the first byte of each packet, and only together with bus_val.
- R4: bus_eop is high together with the byte written with in_last set. In the next cycle bus_val and bus_eop are low, and that same cycle may carry bus_sel for the next port.
- R5: bus_sel and bus_val are never high in the same cycle.
- R6: A byte is sent (bus_val high) only when link_ren was high at the previous edge. In any cycle where both bus_sel and bus_val are low, bus_data keeps its previous value.
- R7: A port may be announced only when it holds at least one complete packet or at least MIN_BLOCK bytes. A port holding fewer bytes and no packet end is never announced.
- R8: Eligible ports are granted in rotating order, starting from the port after the last one granted. After reset the search starts at port 0.
- R9: A burst ends when its queue runs empty before a packet end. That burst carries no bus_eop, and the next burst from that port carries no bus_sop.
- R10: in_full[p] is high exactly when port p holds DEPTH bytes. A write to a full port is not allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_wr | input | 1 | Write one byte into the queue selected by in_port |
| in_port | input | PW | Target queue of the write |
| in_byte | input | DW | Byte to queue |
| in_last | input | 1 | The byte is the last of its packet |
| in_full | output | NP | Per-port queue full |
| link_ren | input | 1 | Link device ready to take data |
| bus_data | output | DW | Port index during select, packet byte during valid |
| bus_sel | output | 1 | Port select (address) cycle |
| bus_val | output | 1 | Packet byte valid |
| bus_sop | output | 1 | First byte of a packet |
| bus_eop | output | 1 | Last byte of a packet |

## Verification
Two events can fall in the same cycle: one port's packet close (valid and end marker dropping) and the next port's select cycle. The stimulus provokes this by queuing complete packets on all four ports while the enable is low, then releasing the enable so the ports drain one after another. The bench judges each select cycle that directly follows an end-marker cycle. It requires that such cycles occur, that valid is low in them, and that the following bytes belong to the newly announced port. A second overlap, enable dropping in the cycle a burst would start or end, comes from a periodic enable pattern during that drain. It is judged by comparing the byte stream of every port with its queue contents.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic {
    ST_ARB  = 1'b0,
    ST_XFER = 1'b1
  } mrx_state_e;

  // Rotating pick: the first requesting index after 'last', wrapping over np ports.
  function automatic int unsigned rr_next(input logic [31:0] req,
                                          input int unsigned last,
                                          input int unsigned np);
    int unsigned pick;
    pick = last;
    for (int k = 32; k >= 1; k--) begin
      if (k <= int'(np)) begin
        if (req[(last + k) % np]) pick = (last + k) % np;
      end
    end
    return pick;
  endfunction

  // A port may open a burst with a whole packet or a minimum block of bytes.
  function automatic logic can_start(input int unsigned level,
                                     input int unsigned pkts,
                                     input int unsigned min_blk);
    return (pkts != 0) || (level >= min_blk);
  endfunction

endpackage

// File: rtl/mrx_port_queue.sv
module mrx_port_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1),
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_byte,
  input  logic          wr_last,
  input  logic          rd_en,
  output logic [DW-1:0] rd_byte,
  output logic          rd_last,
  output logic [LW-1:0] level,
  output logic [LW-1:0] pkts,
  output logic          full
);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= {wr_last, wr_byte};
  end

  assign rd_byte = mem[rp_q][DW-1:0];
  assign rd_last = mem[rp_q][DW];
  assign full    = (level == LW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      level <= '0;
      pkts  <= '0;
    end else begin
      if (wr_en) wp_q <= bump(wp_q);
      if (rd_en) rp_q <= bump(rp_q);
      case ({wr_en, rd_en})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      case ({wr_en && wr_last, rd_en && rd_last})
        2'b10:   pkts <= pkts + 1'b1;
        2'b01:   pkts <= pkts - 1'b1;
        default: pkts <= pkts;
      endcase
    end
  end

  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (level != '0));

endmodule

// File: rtl/mrx_rr_arb.sv
module mrx_rr_arb
  import mrx_pkg::*;
#(
  parameter int NP = 4,
  parameter int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  input  logic          adv,
  output logic [PW-1:0] gnt,
  output logic          any
);

  logic [PW-1:0] last_q;
  logic [31:0]   req_w;

  assign req_w = 32'(req);
  assign any   = |req;
  assign gnt   = PW'(rr_next(req_w, 32'(last_q), NP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= PW'(NP - 1);
    else if (adv) last_q <= gnt;
  end

  assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> req[gnt]);

endmodule

// File: rtl/mport_rx_sender.sv
module mport_rx_sender
  import mrx_pkg::*;
#(
  parameter int NP        = 4,
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int MIN_BLOCK = 8,
  parameter int PW        = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_wr,
  input  logic [PW-1:0] in_port,
  input  logic [DW-1:0] in_byte,
  input  logic          in_last,
  output logic [NP-1:0] in_full,
  input  logic          link_ren,
  output logic [DW-1:0] bus_data,
  output logic          bus_sel,
  output logic          bus_val,
  output logic          bus_sop,
  output logic          bus_eop
);

  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] q_head  [NP];
  logic          q_last  [NP];
  logic [LW-1:0] q_level [NP];
  logic [LW-1:0] q_pkts  [NP];
  logic [NP-1:0] q_wr, q_rd, elig;

  mrx_state_e    st_q;
  logic [PW-1:0] cur_q;
  logic [NP-1:0] mid_q;
  logic [PW-1:0] arb_gnt;
  logic          arb_any;

  // named internal events
  logic evt_announce, evt_beat, evt_burst_end, head_last;
  logic [LW-1:0] cur_level;

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign q_wr[p] = in_wr && (in_port == PW'(p));
    assign q_rd[p] = evt_beat && (cur_q == PW'(p));
    assign elig[p] = can_start(32'(q_level[p]), 32'(q_pkts[p]), MIN_BLOCK);

    mrx_port_queue #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (q_wr[p]),
      .wr_byte (in_byte),
      .wr_last (in_last),
      .rd_en   (q_rd[p]),
      .rd_byte (q_head[p]),
      .rd_last (q_last[p]),
      .level   (q_level[p]),
      .pkts    (q_pkts[p]),
      .full    (in_full[p])
    );
  end

  mrx_rr_arb #(.NP(NP), .PW(PW)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (elig),
    .adv   (evt_announce),
    .gnt   (arb_gnt),
    .any   (arb_any)
  );

  assign head_last     = q_last[cur_q];
  assign cur_level     = q_level[cur_q];
  assign evt_announce  = (st_q == ST_ARB) && link_ren && arb_any;
  assign evt_beat      = (st_q == ST_XFER) && link_ren;
  assign evt_burst_end = evt_beat && (head_last || (cur_level == LW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_ARB;
      cur_q    <= '0;
      mid_q    <= '0;
      bus_data <= '0;
      bus_sel  <= 1'b0;
      bus_val  <= 1'b0;
      bus_sop  <= 1'b0;
      bus_eop  <= 1'b0;
    end else begin
      bus_sel <= evt_announce;
      bus_val <= evt_beat;
      bus_sop <= evt_beat && !mid_q[cur_q];
      bus_eop <= evt_beat && head_last;
      if (evt_announce) begin
        bus_data <= DW'(arb_gnt);
        cur_q    <= arb_gnt;
        st_q     <= ST_XFER;
      end
      if (evt_beat) begin
        bus_data     <= q_head[cur_q];
        mid_q[cur_q] <= !head_last;
        if (evt_burst_end) st_q <= ST_ARB;
      end
    end
  end

  assert_sel_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> !bus_sel);
  assert_sel_after_ren_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> $past(link_ren));
  assert_sop_with_val_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sop |-> bus_val);
  assert_eop_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_eop |=> (!bus_val && !bus_eop));
  assert_sel_val_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_val));
  assert_val_after_ren_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_val |-> $past(link_ren));
  assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel && !bus_val) |-> $stable(bus_data));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_wr |-> !in_full[in_port]);

endmodule

// File: tb/mport_rx_sender_bench.sv
module mport_rx_sender_bench;
  localparam int CLK_P = 10;
  localparam int NP = 4, DW = 8, DEPTH = 16, MINB = 8, PW = 2;
  localparam int NT = 8;
  localparam int TBL_PORT [NT] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam int TBL_LEN  [NT] = '{5, 1, 7, 3, 9, 12, 2, 13};

  logic clk = 0, rst_n = 0;
  logic in_wr = 0, in_last = 0, link_ren = 0;
  logic [PW-1:0] in_port = '0;
  logic [DW-1:0] in_byte = '0;
  logic [NP-1:0] in_full;
  logic [DW-1:0] bus_data;
  logic bus_sel, bus_val, bus_sop, bus_eop;

  mport_rx_sender #(.NP(NP), .DW(DW), .DEPTH(DEPTH), .MIN_BLOCK(MINB)) u_mport_rx_sender (
    .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_port(in_port), .in_byte(in_byte),
    .in_last(in_last), .in_full(in_full), .link_ren(link_ren), .bus_data(bus_data),
    .bus_sel(bus_sel), .bus_val(bus_val), .bus_sop(bus_sop), .bus_eop(bus_eop));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [8:0] expq [NP][$];
  bit exp_start [NP] = '{1, 1, 1, 1};
  int ann_log [64];
  int ann_n = 0, sop_n = 0, eop_n = 0, back2back = 0, mon_cur = 0, salt = 0, cyc = 0;
  int ren_mode = 0;
  logic prev_eop = 0;
  logic [DW-1:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // link enable: 0 low, 1 high, 2 high except one cycle in five
  always @(negedge clk) begin
    cyc++;
    link_ren <= (ren_mode == 1) || (ren_mode == 2 && (cyc % 5) != 3);
  end

  // bus monitor and packet reassembly
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_sel) begin
        chk(!bus_val, "R5 sel with val", int'(bus_val), 0);
        chk(bus_data < NP, "R2 port index", int'(bus_data), 0);
        if (ann_n < 64) ann_log[ann_n] = int'(bus_data);
        ann_n++;
        mon_cur = int'(bus_data) % NP;
        if (prev_eop) back2back++;
      end
      if (bus_val) begin
        if (expq[mon_cur].size() == 0) begin
          chk(0, "R3 unexpected byte", int'(bus_data), -1);
        end else begin
          logic [8:0] e;
          e = expq[mon_cur].pop_front();
          chk(bus_data == e[7:0], "R3 data", int'(bus_data), int'(e[7:0]));
          chk(bus_eop == e[8], "R4 eop", int'(bus_eop), int'(e[8]));
          chk(bus_sop == exp_start[mon_cur], "R3 sop", int'(bus_sop), int'(exp_start[mon_cur]));
          exp_start[mon_cur] = e[8];
        end
        if (bus_sop) sop_n++;
        if (bus_eop) eop_n++;
      end
      if (!bus_val && !bus_sel)
        chk(bus_data == prev_data, "R6 bus hold", int'(bus_data), int'(prev_data));
      if (!bus_val) chk(!bus_sop && !bus_eop, "R3 markers without val", int'({bus_sop, bus_eop}), 0);
      prev_eop  = bus_eop;
      prev_data = bus_data;
    end
  end

  task automatic put(input int p, input logic [7:0] b, input bit last);
    in_wr = 1; in_port = PW'(p); in_byte = b; in_last = last;
    expq[p].push_back({last, b});
    @(negedge clk);
    in_wr = 0; in_last = 0;
  endtask

  task automatic put_pkt(input int p, input int len, input bit close);
    for (int k = 0; k < len; k++) begin
      salt++;
      put(p, 8'(p * 61 + salt * 7), close && (k == len - 1));
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 600; i++) begin
      if (expq[0].size() + expq[1].size() + expq[2].size() + expq[3].size() == 0) break;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base, s0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({bus_sel, bus_val, bus_sop, bus_eop} == 4'b0, "R1 strobes", int'({bus_sel, bus_val, bus_sop, bus_eop}), 0);
    chk(bus_data == 0, "R1 data", int'(bus_data), 0);
    chk(in_full == 0, "R1 full", int'(in_full), 0);

    // table: load with enable low, then drain under a gapped enable
    for (int i = 0; i < NT; i++) put_pkt(TBL_PORT[i], TBL_LEN[i], 1);
    repeat (3) @(negedge clk);
    chk(ann_n == 0, "R2 no select while enable low", ann_n, 0);
    chk(in_full == 4'b1000, "R10 full flag", int'(in_full), 8);
    ren_mode = 2;
    drain();
    chk(ann_n == NT, "R8 burst count", ann_n, NT);
    for (int i = 0; i < NT; i++)
      chk(ann_log[i] == TBL_PORT[i], "R8 table order", ann_log[i], TBL_PORT[i]);
    chk(back2back > 0, "R4 select right after eop", back2back, 1);
    chk(in_full == 0, "R10 full cleared", int'(in_full), 0);

    // rotation from last grant (port 3)
    ren_mode = 0; @(negedge clk);
    base = ann_n;
    put_pkt(2, 2, 1); put_pkt(1, 3, 1);
    ren_mode = 1; drain();
    chk(ann_log[base] == 1, "R8 after port 3 pick 1", ann_log[base], 1);
    chk(ann_log[base+1] == 2, "R8 then 2", ann_log[base+1], 2);
    ren_mode = 0; @(negedge clk);
    base = ann_n;
    put_pkt(1, 1, 1); put_pkt(3, 4, 1);
    ren_mode = 1; drain();
    chk(ann_log[base] == 3, "R8 after port 2 pick 3", ann_log[base], 3);
    chk(ann_log[base+1] == 1, "R8 wrap to 1", ann_log[base+1], 1);

    // partial burst on minimum block
    ren_mode = 0; @(negedge clk);
    base = ann_n; s0 = sop_n; e0 = eop_n;
    put_pkt(0, 8, 0);
    ren_mode = 1; drain();
    chk(ann_n == base + 1, "R9 one partial burst", ann_n, base + 1);
    chk(sop_n == s0 + 1, "R9 sop on first part", sop_n, s0 + 1);
    chk(eop_n == e0, "R9 no eop on partial", eop_n, e0);
    chk(!bus_val, "R9 burst closed", int'(bus_val), 0);
    put_pkt(0, 2, 1); drain();
    chk(ann_n == base + 2, "R9 continuation burst", ann_n, base + 2);
    chk(sop_n == s0 + 1, "R9 no sop on continuation", sop_n, s0 + 1);
    chk(eop_n == e0 + 1, "R9 eop at packet end", eop_n, e0 + 1);

    // threshold: below minimum block stays silent
    base = ann_n;
    put_pkt(2, MINB - 1, 0);
    repeat (20) @(negedge clk);
    chk(ann_n == base, "R7 below block not announced", ann_n, base);
    chk(!bus_val, "R7 no bytes below block", int'(bus_val), 0);
    put_pkt(2, 1, 0);
    repeat (20) @(negedge clk);
    chk(ann_n == base + 1, "R7 block reached", ann_n, base + 1);
    put_pkt(2, 1, 1);
    drain();
    chk(ann_n == base + 2, "R7 tail sent", ann_n, base + 2);

    for (int p = 0; p < NP; p++)
      chk(expq[p].size() == 0, "R3 all bytes delivered", expq[p].size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule